// File: doc/BRIEF.md
# Dual-Priority Conversion Sequencer

This block drives an external analog-to-digital converter through two programmable channel lists. A normal list of up to 16 entries runs on a normal trigger. A priority list of up to 4 entries runs on its own trigger and may interrupt normal work. The block handles the converter enable and the power-up stabilisation wait. It also runs a calibration command and holds back conversions of the on-chip temperature and reference channels until the sensor supply is ready. The normal list leaves its results in one data register with a valid flag. The priority list leaves each result in its own register, chosen by list position.

Software programs the block through a simple write port: control, two wait counts, the list lengths and the two channel tables. The converter handshake has four signals. A one-cycle `conv_start` carries the channel on `conv_chan`. The converter answers with `conv_done` and `conv_data`. A new start restarts the converter, so any earlier conversion is dropped. Each list pulses its own end-of-sequence output.

The controller is a single state machine with eight states:
- `S_OFF`: disabled.
- `S_STAB`: stabilisation wait.
- `S_IDLE`: ready.
- `S_CAL`: calibration running.
- `S_NGO`: normal start pending, or held by the sensor gate.
- `S_NWAIT`: normal conversion in flight.
- `S_PGO`: priority start pending or held.
- `S_PWAIT`: priority conversion in flight.

The transitions are:
- OFF to STAB on enable.
- STAB to IDLE when the count expires.
- IDLE to CAL on a calibration command.
- IDLE to PGO on a priority trigger.
- IDLE to NGO on a normal trigger or a held normal request.
- NGO to NWAIT on a start.
- NWAIT back to NGO for the next entry, or to IDLE at the end of the list.
- NGO or NWAIT to PGO on preemption.
- PGO to PWAIT on a start.
- PWAIT back to PGO for the next entry.
- PWAIT, at the end of the list, to NGO if normal work is interrupted or held, otherwise to IDLE.
- Any state to OFF when enable clears.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Write port map: address 0 is control (bit 0 enable, bit 1 sensor supply, bit 2 calibrate command). After reset, or one cycle after enable is cleared, no start or calibration pulse is issued. In that state `norm_valid` is low, every priority result reads zero, and any interrupted or held work is forgotten.
- R2: After enable is set, no conversion or calibration starts until the count written at address 1 has elapsed. A trigger that arrives during this wait is discarded.
- R3: Writing control with bit 2 set, while enabled, issues one `cal_start` pulse. The block then waits for `conv_done`. Both triggers are discarded while calibration runs.
- R4: A normal trigger converts entries 0 to N of the normal table, in order. Entry i is written at address 16+i, and N is bits [3:0] of address 3. A channel may repeat.
- R5: Each completed normal conversion loads `norm_data` and sets `norm_valid`. A one-cycle `norm_rd` clears `norm_valid`.
- R6: A priority trigger converts entries 0 to M of the priority table. Entry i is written at address 4+i, and M is bits [9:8] of address 3. Result i lands in `prio_data[i*12 +: 12]`.
- R7: Completing the last entry of a list gives one single-cycle pulse on that list's end-of-sequence output (`norm_eos` or `prio_eos`). The two never pulse together.
- R8: A priority trigger during normal work abandons the normal conversion in flight. After the priority list ends, the normal list restarts at the abandoned entry.
- R9: A normal trigger that arrives during priority work is held. The full normal list runs once the priority list ends.
- R10: Channel 17 starts only while control bit 1 is set. A request for it waits until that bit is set.
- R11: Channel 16 starts only once control bit 1 has stayed set for the count written at address 2. The start comes one cycle after the count expires, so the first start is count+1 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| norm_trig | input | 1 | Normal list trigger, one cycle |
| prio_trig | input | 1 | Priority list trigger, one cycle |
| conv_start | output | 1 | Start one conversion |
| cal_start | output | 1 | Start calibration |
| conv_chan | output | 5 | Channel for the start |
| conv_done | input | 1 | Converter finished |
| conv_data | input | 12 | Converter result |
| norm_rd | input | 1 | Read acknowledge for the normal result |
| norm_data | output | 12 | Latest normal result |
| norm_valid | output | 1 | Normal result not yet read |
| prio_data | output | 48 | Priority results, 12 bits per list position |
| norm_eos | output | 1 | Normal list finished |
| prio_eos | output | 1 | Priority list finished |

## Verification
The hardest case to reach is a preemption. The priority trigger has to land while a normal conversion is in flight and before its done arrives, and the bench must then see the abandoned channel start again. The bench gets there by watching `conv_start` for the second normal channel. It fires the priority trigger two cycles later, well inside the converter model's six-cycle latency. The held-trigger and sensor-gate cases work the same way. Each trigger or control write is placed after a known start, and the delay to the next start is counted in cycles.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    typedef enum logic [2:0] {
        S_OFF, S_STAB, S_IDLE, S_CAL, S_NGO, S_NWAIT, S_PGO, S_PWAIT
    } seq_state_t;

    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_STAB   = 1;
    localparam int unsigned A_SETTLE = 2;
    localparam int unsigned A_LEN    = 3;
    localparam int unsigned A_PRIO   = 4;

    localparam int unsigned CTRL_EN   = 0;
    localparam int unsigned CTRL_SENS = 1;
    localparam int unsigned CTRL_CAL  = 2;
    localparam int unsigned LEN_P_LSB = 8;

    localparam int unsigned TEMP_CH = 16;
    localparam int unsigned VREF_CH = 17;
endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (clr) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= limit;
            armed <= 1'b1;
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = armed && (cnt == '0);

    // R2 / R11: an armed count moves down by exactly one per cycle
    a_r2_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !clr && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/adcseq_cfg.sv
module adcseq_cfg
    import adcseq_pkg::*;
#(
    parameter int CH_W   = 5,
    parameter int NLIST  = 16,
    parameter int PLIST  = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5,
    localparam int NIDX_W = $clog2(NLIST),
    localparam int PIDX_W = $clog2(PLIST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [NIDX_W-1:0] n_sel,
    input  logic [PIDX_W-1:0] p_sel,
    output logic              ctl_en,
    output logic              sens_en,
    output logic              cal_cmd,
    output logic [CNT_W-1:0]  stab_lim,
    output logic [CNT_W-1:0]  settle_lim,
    output logic [NIDX_W-1:0] n_last,
    output logic [PIDX_W-1:0] p_last,
    output logic [CH_W-1:0]   n_chan,
    output logic [CH_W-1:0]   p_chan
);
    localparam int LO_W = ADDR_W - 1;

    logic            hi;
    logic [LO_W-1:0] lo;
    logic [CH_W-1:0] ntab [NLIST];
    logic [CH_W-1:0] ptab [PLIST];

    assign hi = addr[ADDR_W-1];
    assign lo = addr[LO_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en     <= 1'b0;
            sens_en    <= 1'b0;
            cal_cmd    <= 1'b0;
            stab_lim   <= '0;
            settle_lim <= '0;
            n_last     <= '0;
            p_last     <= '0;
        end else begin
            cal_cmd <= 1'b0;
            if (we && !hi) begin
                unique case (lo)
                    LO_W'(A_CTRL): begin
                        ctl_en  <= wdata[CTRL_EN];
                        sens_en <= wdata[CTRL_SENS];
                        cal_cmd <= wdata[CTRL_CAL];
                    end
                    LO_W'(A_STAB):   stab_lim   <= wdata;
                    LO_W'(A_SETTLE): settle_lim <= wdata;
                    LO_W'(A_LEN): begin
                        n_last <= wdata[NIDX_W-1:0];
                        p_last <= wdata[LEN_P_LSB +: PIDX_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NLIST; g++) begin : g_ntab
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ntab[g] <= '0;
            else if (we && hi && lo == LO_W'(g))
                ntab[g] <= wdata[CH_W-1:0];
        end
    end

    for (genvar g = 0; g < PLIST; g++) begin : g_ptab
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptab[g] <= '0;
            else if (we && !hi && lo == LO_W'(A_PRIO + g))
                ptab[g] <= wdata[CH_W-1:0];
        end
    end

    assign n_chan = ntab[n_sel];
    assign p_chan = ptab[p_sel];
endmodule

// File: rtl/adcseq_results.sv
module adcseq_results #(
    parameter int DATA_W = 12,
    parameter int PLIST  = 4,
    localparam int PIDX_W = $clog2(PLIST)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    n_wr,
    input  logic                    p_wr,
    input  logic [PIDX_W-1:0]       p_sel,
    input  logic [DATA_W-1:0]       din,
    input  logic                    rd,
    output logic [DATA_W-1:0]       norm_data,
    output logic                    norm_valid,
    output logic [PLIST*DATA_W-1:0] prio_flat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            norm_data  <= '0;
            norm_valid <= 1'b0;
        end else if (clr) begin
            norm_data  <= '0;
            norm_valid <= 1'b0;
        end else if (n_wr) begin
            norm_data  <= din;
            norm_valid <= 1'b1;
        end else if (rd) begin
            norm_valid <= 1'b0;
        end
    end

    for (genvar g = 0; g < PLIST; g++) begin : g_pres
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_flat[g*DATA_W +: DATA_W] <= '0;
            else if (clr)
                prio_flat[g*DATA_W +: DATA_W] <= '0;
            else if (p_wr && p_sel == PIDX_W'(g))
                prio_flat[g*DATA_W +: DATA_W] <= din;
        end
    end

    // R5: a completed normal conversion leaves a valid result behind
    a_r5_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (n_wr && !clr) |=> norm_valid);
    // R5: a read without a new result clears the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !n_wr) |=> !norm_valid);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int CH_W   = 5,
    parameter int DATA_W = 12,
    parameter int NLIST  = 16,
    parameter int PLIST  = 4,
    parameter int CNT_W  = 16,
    localparam int NIDX_W = $clog2(NLIST),
    localparam int PIDX_W = $clog2(PLIST),
    localparam int ADDR_W = ((NIDX_W > 3) ? NIDX_W : 3) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [CNT_W-1:0]        cfg_wdata,
    input  logic                    norm_trig,
    input  logic                    prio_trig,
    output logic                    conv_start,
    output logic                    cal_start,
    output logic [CH_W-1:0]         conv_chan,
    input  logic                    conv_done,
    input  logic [DATA_W-1:0]       conv_data,
    input  logic                    norm_rd,
    output logic [DATA_W-1:0]       norm_data,
    output logic                    norm_valid,
    output logic [PLIST*DATA_W-1:0] prio_data,
    output logic                    norm_eos,
    output logic                    prio_eos
);
    seq_state_t        state, nxt;
    logic              ctl_en, sens_en, cal_cmd, sens_q;
    logic [CNT_W-1:0]  stab_lim, settle_lim;
    logic [NIDX_W-1:0] n_last, n_idx;
    logic [PIDX_W-1:0] p_last, p_idx;
    logic [CH_W-1:0]   n_chan, p_chan;
    logic              n_busy, n_pend, cal_req;
    logic              stab_ok, settle_ok, gate_n, gate_p;
    logic              n_wr, p_wr;

    adcseq_cfg #(
        .CH_W(CH_W), .NLIST(NLIST), .PLIST(PLIST), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .n_sel(n_idx), .p_sel(p_idx), .ctl_en(ctl_en), .sens_en(sens_en),
        .cal_cmd(cal_cmd), .stab_lim(stab_lim), .settle_lim(settle_lim),
        .n_last(n_last), .p_last(p_last), .n_chan(n_chan), .p_chan(p_chan)
    );

    adcseq_timer #(.CNT_W(CNT_W)) u_stab (
        .clk(clk), .rst_n(rst_n), .clr(!ctl_en),
        .load(ctl_en && state == S_OFF), .limit(stab_lim), .expired(stab_ok)
    );

    adcseq_timer #(.CNT_W(CNT_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(!sens_en),
        .load(sens_en && !sens_q), .limit(settle_lim), .expired(settle_ok)
    );

    adcseq_results #(.DATA_W(DATA_W), .PLIST(PLIST)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(!ctl_en), .n_wr(n_wr), .p_wr(p_wr),
        .p_sel(p_idx), .din(conv_data), .rd(norm_rd), .norm_data(norm_data),
        .norm_valid(norm_valid), .prio_flat(prio_data)
    );

    // Sensor gate: temperature needs supply plus settling, reference needs supply
    assign gate_n = !((n_chan == CH_W'(TEMP_CH)) && !(sens_en && settle_ok))
                 && !((n_chan == CH_W'(VREF_CH)) && !sens_en);
    assign gate_p = !((p_chan == CH_W'(TEMP_CH)) && !(sens_en && settle_ok))
                 && !((p_chan == CH_W'(VREF_CH)) && !sens_en);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        if (!ctl_en) begin
            nxt = S_OFF;
        end else begin
            unique case (state)
                S_OFF:  nxt = S_STAB;
                S_STAB: if (stab_ok) nxt = S_IDLE;
                S_IDLE: begin
                    if (cal_req)                  nxt = S_CAL;
                    else if (prio_trig)           nxt = S_PGO;
                    else if (norm_trig || n_pend) nxt = S_NGO;
                end
                S_CAL:  if (conv_done) nxt = S_IDLE;
                S_NGO: begin
                    if (prio_trig)   nxt = S_PGO;
                    else if (gate_n) nxt = S_NWAIT;
                end
                S_NWAIT: begin
                    if (prio_trig)      nxt = S_PGO;
                    else if (conv_done) nxt = (n_idx == n_last) ? S_IDLE : S_NGO;
                end
                S_PGO:  if (gate_p) nxt = S_PWAIT;
                S_PWAIT: begin
                    if (conv_done) begin
                        if (p_idx != p_last)                     nxt = S_PGO;
                        else if (n_busy || n_pend || norm_trig) nxt = S_NGO;
                        else                                     nxt = S_IDLE;
                    end
                end
                default: nxt = S_OFF;
            endcase
        end
    end

    // List positions, interrupted and held normal work, calibration request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_idx <= '0; p_idx <= '0; n_busy <= 1'b0; n_pend <= 1'b0;
            cal_req <= 1'b0; sens_q <= 1'b0;
        end else begin
            sens_q <= sens_en;
            if (!ctl_en) begin
                n_idx <= '0; p_idx <= '0; n_busy <= 1'b0; n_pend <= 1'b0;
                cal_req <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (cal_req) begin
                            cal_req <= 1'b0;
                        end else if (prio_trig) begin
                            p_idx <= '0;
                            if (norm_trig) n_pend <= 1'b1;
                        end else if (norm_trig || n_pend) begin
                            n_idx <= '0; n_busy <= 1'b1; n_pend <= 1'b0;
                        end
                    end
                    S_NGO, S_NWAIT: begin
                        if (prio_trig) begin
                            p_idx <= '0;
                        end else if (state == S_NWAIT && conv_done) begin
                            if (n_idx == n_last) n_busy <= 1'b0;
                            else                 n_idx  <= n_idx + 1'b1;
                        end
                    end
                    S_PGO: if (norm_trig && !n_busy) n_pend <= 1'b1;
                    S_PWAIT: begin
                        if (conv_done) begin
                            if (p_idx != p_last) begin
                                p_idx <= p_idx + 1'b1;
                            end else if (!n_busy && (n_pend || norm_trig)) begin
                                n_idx <= '0; n_busy <= 1'b1; n_pend <= 1'b0;
                            end
                        end else if (norm_trig && !n_busy) begin
                            n_pend <= 1'b1;
                        end
                    end
                    default: ;
                endcase
                if (cal_cmd) cal_req <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        conv_start = 1'b0;
        cal_start  = 1'b0;
        conv_chan  = n_chan;
        n_wr       = 1'b0;
        p_wr       = 1'b0;
        if (ctl_en) begin
            unique case (state)
                S_IDLE:  cal_start  = cal_req;
                S_NGO:   conv_start = gate_n && !prio_trig;
                S_NWAIT: n_wr       = conv_done && !prio_trig;
                S_PGO: begin
                    conv_start = gate_p;
                    conv_chan  = p_chan;
                end
                S_PWAIT: begin
                    p_wr      = conv_done;
                    conv_chan = p_chan;
                end
                default: ;
            endcase
        end
    end

    assign norm_eos = n_wr && (n_idx == n_last);
    assign prio_eos = p_wr && (p_idx == p_last);

    // R1: clearing enable returns the sequencer to its idle reset state
    a_r1_disable_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (state == S_OFF) && !n_busy && !n_pend);
    // R2: nothing starts before the stabilisation count has expired
    a_r2_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start || cal_start) |-> stab_ok);
    // R7: the two end-of-sequence pulses never coincide
    a_r7_eos_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({norm_eos, prio_eos}));
    // R8: preemption keeps the interrupted normal position
    a_r8_resume_point: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !cfg_we && state == S_NWAIT && prio_trig)
            |=> (state == S_PGO) && n_busy && $stable(n_idx));
    // R10: reference channel only with the sensor supply on
    a_r10_vref_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_chan == CH_W'(VREF_CH)) |-> sens_en);
    // R11: temperature channel only after settling
    a_r11_temp_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_chan == CH_W'(TEMP_CH)) |-> (sens_en && settle_ok));
    // R3: calibration and conversion starts are exclusive
    a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({conv_start, cal_start}));
endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
    localparam int CH_W = 5, DATA_W = 12, PLIST = 4, LAT = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic norm_trig = 1'b0, prio_trig = 1'b0, norm_rd = 1'b0;
    logic conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic conv_start, cal_start, norm_valid, norm_eos, prio_eos;
    logic [CH_W-1:0] conv_chan;
    logic [DATA_W-1:0] norm_data;
    logic [PLIST*DATA_W-1:0] prio_data;

    always #2.5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .norm_trig(norm_trig), .prio_trig(prio_trig),
        .conv_start(conv_start), .cal_start(cal_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .norm_rd(norm_rd),
        .norm_data(norm_data), .norm_valid(norm_valid), .prio_data(prio_data),
        .norm_eos(norm_eos), .prio_eos(prio_eos)
    );

    int checks = 0, errors = 0, cyc = 0;
    int starts = 0, cal_cnt = 0, neos = 0, peos = 0, start_cyc = 0;
    int exp_q[$];
    string cur_req = "R4";
    int cv_cnt = 0;
    logic [CH_W-1:0] cv_ch = '0;
    bit cv_fire = 1'b0, finished = 1'b0;

    function automatic logic [DATA_W-1:0] fdat(int ch);
        return DATA_W'((ch * 37 + 5) % 4096);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Reference monitor and converter model, sampled mid-cycle
    always @(negedge clk) begin
        int e;
        if (rst_n) begin
            if (conv_start) begin
                starts++;
                start_cyc = cyc;
                if (exp_q.size() == 0) check(1'b0, cur_req, int'(conv_chan), -1);
                else begin
                    e = exp_q.pop_front();
                    check(int'(conv_chan) == e, cur_req, int'(conv_chan), e);
                end
            end
            if (cal_start) cal_cnt++;
            if (norm_eos) neos++;
            if (prio_eos) peos++;
            if (conv_start || cal_start) begin
                cv_cnt = LAT; cv_ch = conv_chan; cv_fire = 1'b0;
            end else if (cv_cnt > 0) begin
                cv_cnt--;
                if (cv_cnt == 0) cv_fire = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        conv_done = 1'b0;
        if (cv_fire) begin
            conv_done = 1'b1;
            conv_data = fdat(int'(cv_ch));
            cv_fire = 1'b0;
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_n();
        @(posedge clk); #1; norm_trig = 1'b1;
        @(posedge clk); #1; norm_trig = 1'b0;
    endtask

    task automatic pulse_p();
        @(posedge clk); #1; prio_trig = 1'b1;
        @(posedge clk); #1; prio_trig = 1'b0;
    endtask

    task automatic settle_out();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (LAT + 6) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int s0, c0, n0, p0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        check(!conv_start && !cal_start, "R1", conv_start, 0);
        check(!norm_valid, "R1", norm_valid, 0);
        check(prio_data == '0, "R1", int'(prio_data[11:0]), 0);

        // R2 stabilisation wait, early trigger discarded
        cur_req = "R2";
        wr(1, 5);
        wr(0, 1);
        pulse_n();
        pulse_p();
        repeat (12) @(posedge clk);
        check(starts == 0, "R2", starts, 0);

        // R3 calibration, triggers ignored while it runs
        cur_req = "R3";
        wr(0, 5);
        repeat (2) @(posedge clk);
        pulse_n();
        pulse_p();
        repeat (15) @(posedge clk);
        check(cal_cnt == 1, "R3", cal_cnt, 1);
        check(starts == 0, "R3", starts, 0);

        // R4 normal list with a repeated channel, R5 result, R7 pulse
        cur_req = "R4";
        wr(16, 3); wr(17, 5); wr(18, 3);
        wr(3, (1 << 8) | 2);
        exp_q.push_back(3); exp_q.push_back(5); exp_q.push_back(3);
        pulse_n();
        settle_out();
        check(neos == 1, "R7", neos, 1);
        check(norm_valid == 1'b1, "R5", norm_valid, 1);
        check(norm_data == fdat(3), "R5", int'(norm_data), int'(fdat(3)));
        @(posedge clk); #1 norm_rd = 1'b1;
        @(posedge clk); #1 norm_rd = 1'b0;
        @(negedge clk);
        check(norm_valid == 1'b0, "R5", norm_valid, 0);

        // R6 priority list by position
        cur_req = "R6";
        wr(4, 7); wr(5, 9);
        exp_q.push_back(7); exp_q.push_back(9);
        pulse_p();
        settle_out();
        check(peos == 1, "R7", peos, 1);
        check(prio_data[0 +: 12] == fdat(7), "R6", int'(prio_data[0 +: 12]), int'(fdat(7)));
        check(prio_data[12 +: 12] == fdat(9), "R6", int'(prio_data[12 +: 12]), int'(fdat(9)));

        // R8 preemption of an in-flight normal conversion
        cur_req = "R8";
        wr(16, 1); wr(17, 2); wr(18, 3); wr(19, 4);
        wr(3, (1 << 8) | 3);
        wr(4, 10); wr(5, 11);
        exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(10);
        exp_q.push_back(11); exp_q.push_back(2); exp_q.push_back(3);
        exp_q.push_back(4);
        n0 = neos; p0 = peos; s0 = starts;
        pulse_n();
        while (starts < s0 + 2) @(negedge clk);
        pulse_p();
        settle_out();
        check(peos == p0 + 1, "R8", peos - p0, 1);
        check(neos == n0 + 1, "R8", neos - n0, 1);
        check(prio_data[12 +: 12] == fdat(11), "R8", int'(prio_data[12 +: 12]), int'(fdat(11)));
        check(norm_data == fdat(4), "R8", int'(norm_data), int'(fdat(4)));

        // R9 normal trigger held during priority work
        cur_req = "R9";
        wr(16, 5); wr(17, 6);
        wr(3, (1 << 8) | 1);
        exp_q.push_back(10); exp_q.push_back(11);
        exp_q.push_back(5); exp_q.push_back(6);
        n0 = neos;
        pulse_p();
        repeat (3) @(posedge clk);
        pulse_n();
        settle_out();
        check(neos == n0 + 1, "R9", neos - n0, 1);
        check(norm_data == fdat(6), "R9", int'(norm_data), int'(fdat(6)));

        // R11 temperature channel waits for supply plus settling
        cur_req = "R11";
        wr(2, 10);
        wr(16, 16);
        wr(3, (1 << 8) | 0);
        exp_q.push_back(16);
        s0 = starts;
        pulse_n();
        repeat (20) @(posedge clk);
        check(starts == s0, "R11", starts - s0, 0);
        wr(0, 3);
        c0 = cyc;
        settle_out();
        check(start_cyc - c0 == 11, "R11", start_cyc - c0, 11);

        // R10 reference channel waits for supply only
        cur_req = "R10";
        wr(0, 1);
        wr(16, 17);
        exp_q.push_back(17);
        s0 = starts;
        pulse_n();
        repeat (15) @(posedge clk);
        check(starts == s0, "R10", starts - s0, 0);
        wr(0, 3);
        c0 = cyc;
        settle_out();
        check(start_cyc - c0 == 0, "R10", start_cyc - c0, 0);

        // R1 disable mid-list
        cur_req = "R1";
        wr(16, 1); wr(17, 2); wr(18, 3); wr(19, 4);
        wr(3, (1 << 8) | 3);
        exp_q.push_back(1);
        s0 = starts; n0 = neos;
        pulse_n();
        while (starts < s0 + 1) @(negedge clk);
        wr(0, 2);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check(starts == s0 + 1, "R1", starts - s0, 1);
        check(neos == n0, "R1", neos - n0, 0);
        check(!norm_valid, "R1", norm_valid, 0);
        check(prio_data == '0, "R1", int'(prio_data[0 +: 12]), 0);

        finish_run();
    end
endmodule